// File: doc/BRIEF.md
# Synchronous DRAM Burst Memory Model

A compact, synthesizable stand-in for a synchronous DRAM. It sits on the memory side of a bench or an emulation build and lets a DRAM controller exercise its command sequencing. Every command, address, mask and write word is taken on the rising clock edge. A row activation opens one page per bank. Later column commands in that page run as fixed-length bursts driven by an internal column counter. The counter starts at the column given with the command and advances once per clock inside its burst-aligned block, so consecutive words move without new addresses.

Read words leave on a valid-qualified stream (`rd_valid`, `rd_data`) that has no ready input. The model cannot stall. A consumer must take each word in the cycle where `rd_valid` is high, and its only means of flow control is the command stream: a stop command or a new column command ends the burst in progress. Write words enter on `wr_data` and `wr_mask` at fixed clock slots, starting with the write command and continuing on the following clocks.

Top module: `sdram_model`

## Requirements
- R1: After reset, `rd_valid` is 0, `rd_data` is 0 and every bank is closed, so a read issued right after reset returns no words.
- R2: The command is the 4-bit code {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n}. The codes are: 0011 activate, 0101 read, 0100 write, 0010 precharge, 0110 burst stop. 0111, any code with cmd_cs_n high, and every other code change nothing.
- R3: Activate opens row `addr[ROW_W-1:0]` in bank `bank`. An activate aimed at a bank that is already open is ignored, and the open row is kept.
- R4: Precharge with `addr[ADDR_W-1]` low closes bank `bank`. A read or a write to a closed bank is ignored: it returns no data and stores nothing.
- R5: A read to an open bank puts its first word on `rd_data` with `rd_valid` high exactly CL clocks after the edge that took the command. The remaining BL-1 words follow on consecutive clocks. `rd_data` is 0 whenever `rd_valid` is low.
- R6: Burst words visit the start column first. The column then increments, wrapping inside the BL-aligned block of columns: with BL=4 a start at column 6 gives columns 6, 7, 4, 5.
- R7: Write word 0 is taken with the write command, and word k is taken k clocks later, in the column order of R6. A high `wr_mask[i]` leaves byte i (bits 8i+7..8i) of that word unchanged.
- R8: A read or write command issued k clocks after an earlier read or write (0<k<BL) ends the earlier burst after k words. For two reads, the words of both bursts arrive back to back.
- R9: A burst stop issued k clocks after a read or write (0<k<BL) limits that burst to k words. The write word presented with the stop is not stored.
- R10: Precharge with `addr[ADDR_W-1]` high closes every bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_cs_n | input | 1 | Chip select, active low |
| cmd_ras_n | input | 1 | Row strobe, active low |
| cmd_cas_n | input | 1 | Column strobe, active low |
| cmd_we_n | input | 1 | Write enable, active low |
| bank | input | NB_W | Bank select |
| addr | input | ADDR_W | Row (activate) or column (read/write); MSB picks all banks on precharge |
| wr_mask | input | DW/8 | Per-byte write mask, high blocks the lane |
| wr_data | input | DW | Write word |
| rd_data | output | DW | Read word, zero when not valid |
| rd_valid | output | 1 | Read word present this cycle |

## Verification
The bench uses the default build: 4 banks, 16 rows, 16 columns, 32-bit words, BL=4, CL=2. This array is small enough that the bench fills every word with known data before any read, so a read from a wrong row, bank or column always shows up as a data mismatch. Sixteen columns hold four aligned blocks, so starts at every offset in a block reach the wrap of R6. Because CL=2 keeps a gap between issue and arrival, an interruption after two words (R8, R9) shows the hand-over between bursts on consecutive cycles.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_OPEN,
    OP_READ,
    OP_WRITE,
    OP_CLOSE,
    OP_HALT
  } sdm_op_e;

  function automatic sdm_op_e sdm_decode(input logic cs_n, input logic ras_n,
                                         input logic cas_n, input logic we_n);
    sdm_op_e op;
    op = OP_IDLE;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b011:  op = OP_OPEN;
        3'b101:  op = OP_READ;
        3'b100:  op = OP_WRITE;
        3'b010:  op = OP_CLOSE;
        3'b110:  op = OP_HALT;
        default: op = OP_IDLE;
      endcase
    end
    return op;
  endfunction

endpackage

// File: rtl/sdm_cmd_decode.sv
module sdm_cmd_decode
  import sdm_pkg::*;
(
  input  logic    cs_n,
  input  logic    ras_n,
  input  logic    cas_n,
  input  logic    we_n,
  output sdm_op_e op
);
  always_comb op = sdm_decode(cs_n, ras_n, cas_n, we_n);
endmodule

// File: rtl/sdm_bank_table.sv
module sdm_bank_table
  import sdm_pkg::*;
#(
  parameter int NB_W   = 2,
  parameter int ROW_W  = 4,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sdm_op_e           op,
  input  logic [NB_W-1:0]   bank,
  input  logic [ADDR_W-1:0] addr,
  output logic [(1<<NB_W)-1:0] open_mask,
  output logic              sel_open,
  output logic [ROW_W-1:0]  sel_row
);
  localparam int NB = 1 << NB_W;

  logic [NB*ROW_W-1:0] rows_flat;
  logic                all_banks;

  assign all_banks = addr[ADDR_W-1];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic             open_r;
    logic [ROW_W-1:0] row_r;
    logic             hit;

    assign hit = (bank == NB_W'(b));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_r <= 1'b0;
        row_r  <= '0;
      end else begin
        if (op == OP_OPEN && hit && !open_r) begin
          open_r <= 1'b1;
          row_r  <= addr[ROW_W-1:0];
        end else if (op == OP_CLOSE && (hit || all_banks)) begin
          open_r <= 1'b0;
        end
      end
    end

    assign open_mask[b]                  = open_r;
    assign rows_flat[b*ROW_W +: ROW_W]   = row_r;
  end

  assign sel_open = open_mask[bank];
  assign sel_row  = rows_flat[bank*ROW_W +: ROW_W];

endmodule

// File: rtl/sdm_burst_engine.sv
module sdm_burst_engine #(
  parameter int NB_W  = 2,
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  parameter int BL    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_go,
  input  logic             wr_go,
  input  logic             halt,
  input  logic [NB_W-1:0]  bank,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  output logic             issue_rd,
  output logic             issue_wr,
  output logic [NB_W-1:0]  e_bank,
  output logic [ROW_W-1:0] e_row,
  output logic [COL_W-1:0] e_col
);
  localparam int LBL   = $clog2(BL);
  localparam int CNT_W = LBL + 1;

  logic [CNT_W-1:0] cnt_q;
  logic             wr_mode_q;
  logic             active;

  function automatic logic [COL_W-1:0] step_col(input logic [COL_W-1:0] c);
    logic [COL_W-1:0] n;
    n = c;
    n[LBL-1:0] = c[LBL-1:0] + 1'b1;
    return n;
  endfunction

  assign active   = (cnt_q != '0);
  assign issue_rd = active && !wr_mode_q;
  // a write word arriving with a stop or a new read is not stored
  assign issue_wr = active && wr_mode_q && !halt && !rd_go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      wr_mode_q <= 1'b0;
      e_bank    <= '0;
      e_row     <= '0;
      e_col     <= '0;
    end else if (rd_go) begin
      cnt_q     <= CNT_W'(BL);
      wr_mode_q <= 1'b0;
      e_bank    <= bank;
      e_row     <= row;
      e_col     <= col;
    end else if (wr_go) begin
      cnt_q     <= CNT_W'(BL - 1);
      wr_mode_q <= 1'b1;
      e_bank    <= bank;
      e_row     <= row;
      e_col     <= step_col(col);
    end else if (halt) begin
      cnt_q     <= '0;
    end else if (active) begin
      cnt_q     <= cnt_q - 1'b1;
      e_col     <= step_col(e_col);
    end
  end

endmodule

// File: rtl/sdm_array.sv
module sdm_array #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic [AW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_word,
  input  logic            we,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_word,
  input  logic [DW/8-1:0] wr_mask
);
  localparam int DEPTH = 1 << AW;
  localparam int LANES = DW / 8;

  logic [DW-1:0] mem [DEPTH];

  assign rd_word = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int l = 0; l < LANES; l++) begin
        if (!wr_mask[l]) mem[wr_addr][l*8 +: 8] <= wr_word[l*8 +: 8];
      end
    end
  end

endmodule

// File: rtl/sdm_read_pipe.sv
module sdm_read_pipe #(
  parameter int DW = 32,
  parameter int CL = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_word,
  output logic          out_valid,
  output logic [DW-1:0] out_word
);
  logic [CL-1:0] v_q;
  logic [DW-1:0] d_q [CL];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= '0;
      for (int i = 0; i < CL; i++) d_q[i] <= '0;
    end else begin
      v_q[0] <= in_valid;
      d_q[0] <= in_valid ? in_word : '0;
      for (int i = 1; i < CL; i++) begin
        v_q[i] <= v_q[i-1];
        d_q[i] <= d_q[i-1];
      end
    end
  end

  assign out_valid = v_q[CL-1];
  assign out_word  = d_q[CL-1];

endmodule

// File: rtl/sdram_model.sv
module sdram_model
  import sdm_pkg::*;
#(
  parameter int NB_W   = 2,
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4,
  parameter int DW     = 32,
  parameter int BL     = 4,
  parameter int CL     = 2,
  parameter int ADDR_W = ((ROW_W > COL_W) ? ROW_W : COL_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_cs_n,
  input  logic              cmd_ras_n,
  input  logic              cmd_cas_n,
  input  logic              cmd_we_n,
  input  logic [NB_W-1:0]   bank,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW/8-1:0]   wr_mask,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     rd_data,
  output logic              rd_valid
);
  localparam int NB = 1 << NB_W;
  localparam int AW = NB_W + ROW_W + COL_W;

  sdm_op_e           op;
  logic [NB-1:0]     open_mask;
  logic              sel_open;
  logic [ROW_W-1:0]  sel_row;
  logic              rd_go, wr_go, halt;
  logic              issue_rd, issue_wr;
  logic [NB_W-1:0]   e_bank;
  logic [ROW_W-1:0]  e_row;
  logic [COL_W-1:0]  e_col;
  logic [DW-1:0]     arr_word;
  logic              arr_we;
  logic [AW-1:0]     arr_waddr;

  sdm_cmd_decode u_dec (
    .cs_n (cmd_cs_n),
    .ras_n(cmd_ras_n),
    .cas_n(cmd_cas_n),
    .we_n (cmd_we_n),
    .op   (op)
  );

  sdm_bank_table #(.NB_W(NB_W), .ROW_W(ROW_W), .ADDR_W(ADDR_W)) u_banks (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .bank     (bank),
    .addr     (addr),
    .open_mask(open_mask),
    .sel_open (sel_open),
    .sel_row  (sel_row)
  );

  assign rd_go = (op == OP_READ)  && sel_open;
  assign wr_go = (op == OP_WRITE) && sel_open;
  assign halt  = (op == OP_HALT);

  sdm_burst_engine #(.NB_W(NB_W), .ROW_W(ROW_W), .COL_W(COL_W), .BL(BL)) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_go   (rd_go),
    .wr_go   (wr_go),
    .halt    (halt),
    .bank    (bank),
    .row     (sel_row),
    .col     (addr[COL_W-1:0]),
    .issue_rd(issue_rd),
    .issue_wr(issue_wr),
    .e_bank  (e_bank),
    .e_row   (e_row),
    .e_col   (e_col)
  );

  // a write command takes the port ahead of a burst word in flight
  assign arr_we    = wr_go || issue_wr;
  assign arr_waddr = wr_go ? {bank, sel_row, addr[COL_W-1:0]} : {e_bank, e_row, e_col};

  sdm_array #(.AW(AW), .DW(DW)) u_mem (
    .clk    (clk),
    .rd_addr({e_bank, e_row, e_col}),
    .rd_word(arr_word),
    .we     (arr_we),
    .wr_addr(arr_waddr),
    .wr_word(wr_data),
    .wr_mask(wr_mask)
  );

  sdm_read_pipe #(.DW(DW), .CL(CL)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (issue_rd),
    .in_word  (arr_word),
    .out_valid(rd_valid),
    .out_word (rd_data)
  );

endmodule

// File: rtl/sdm_checker.sv
module sdm_checker #(
  parameter int NB_W   = 2,
  parameter int ADDR_W = 5,
  parameter int DW     = 32,
  parameter int BL     = 4,
  parameter int CL     = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cmd_cs_n,
  input logic                  cmd_ras_n,
  input logic                  cmd_cas_n,
  input logic                  cmd_we_n,
  input logic [NB_W-1:0]       bank,
  input logic [ADDR_W-1:0]     addr,
  input logic [DW-1:0]         rd_data,
  input logic                  rd_valid,
  input logic [(1<<NB_W)-1:0]  bank_open
);
  localparam int NB = 1 << NB_W;
  localparam int HW = CL + BL;

  logic          is_act, is_rd, is_pre, rd_acc;
  logic [NB-1:0] opn;
  logic [HW-1:0] hist;

  assign is_act = !cmd_cs_n && ({cmd_ras_n, cmd_cas_n, cmd_we_n} == 3'b011);
  assign is_rd  = !cmd_cs_n && ({cmd_ras_n, cmd_cas_n, cmd_we_n} == 3'b101);
  assign is_pre = !cmd_cs_n && ({cmd_ras_n, cmd_cas_n, cmd_we_n} == 3'b010);
  assign rd_acc = is_rd && opn[bank];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opn  <= '0;
      hist <= '0;
    end else begin
      hist <= {hist[HW-2:0], rd_acc};
      for (int b = 0; b < NB; b++) begin
        if (is_act && bank == NB_W'(b)) opn[b] <= 1'b1;
        else if (is_pre && (bank == NB_W'(b) || addr[ADDR_W-1])) opn[b] <= 1'b0;
      end
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!rd_valid && bank_open == '0));

  p_first_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hist[CL] |-> rd_valid);

  p_valid_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (|hist[HW-1:CL]));

  p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == '0));

  p_pre_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |=> !bank_open[$past(bank)]);

  p_pre_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pre && addr[ADDR_W-1]) |=> (bank_open == '0));

endmodule

bind sdram_model sdm_checker #(
  .NB_W(NB_W), .ADDR_W(ADDR_W), .DW(DW), .BL(BL), .CL(CL)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_cs_n (cmd_cs_n),
  .cmd_ras_n(cmd_ras_n),
  .cmd_cas_n(cmd_cas_n),
  .cmd_we_n (cmd_we_n),
  .bank     (bank),
  .addr     (addr),
  .rd_data  (rd_data),
  .rd_valid (rd_valid),
  .bank_open(open_mask)
);

// File: tb/sim_sdram_model.sv
module sim_sdram_model;
  localparam int CL = 2;
  localparam int BL = 4;
  localparam int ROWS = 16;
  localparam int COLS = 16;
  localparam logic [3:0] C_NOP  = 4'b0111;
  localparam logic [3:0] C_ACT  = 4'b0011;
  localparam logic [3:0] C_RD   = 4'b0101;
  localparam logic [3:0] C_WR   = 4'b0100;
  localparam logic [3:0] C_PRE  = 4'b0010;
  localparam logic [3:0] C_STOP = 4'b0110;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_cs_n = 1'b1, cmd_ras_n = 1'b1, cmd_cas_n = 1'b1, cmd_we_n = 1'b1;
  logic [1:0]  bank = '0;
  logic [4:0]  addr = '0;
  logic [3:0]  wr_mask = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        rd_valid;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  logic [31:0] shadow [BL*0 + 4*ROWS*COLS];
  logic        mopen [4];
  int          mrow  [4];

  logic [31:0] cap_d [16];
  int          cap_c [16];
  int          cap_n = 0;
  logic [31:0] exp_d [16];
  int          exp_c [16];
  int          exp_n = 0;

  sdram_model u0 (
    .clk(clk), .rst_n(rst_n),
    .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n),
    .bank(bank), .addr(addr), .wr_mask(wr_mask), .wr_data(wr_data),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rd_valid && cap_n < 16) begin
      cap_d[cap_n] = rd_data;
      cap_c[cap_n] = cyc;
      cap_n = cap_n + 1;
    end
  end

  function automatic int idx(int b, int r, int c);
    return (b * ROWS + r) * COLS + c;
  endfunction

  function automatic int bcol(int c, int k);
    return (c & ~(BL - 1)) | ((c + k) & (BL - 1));
  endfunction

  function automatic logic [31:0] merge(logic [31:0] old_w, logic [31:0] new_w, logic [3:0] m);
    logic [31:0] r;
    r = old_w;
    for (int l = 0; l < 4; l++) if (!m[l]) r[l*8 +: 8] = new_w[l*8 +: 8];
    return r;
  endfunction

  task automatic issue(input logic [3:0] code, input int b, input int a,
                       input logic [31:0] wd, input logic [3:0] m, output int t);
    @(negedge clk);
    {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} = code;
    bank = 2'(b); addr = 5'(a); wr_data = wd; wr_mask = m;
    t = cyc + 1;
  endtask

  task automatic idle(input int n);
    int t;
    for (int i = 0; i < n; i++) issue(C_NOP, 0, 0, 32'h0, 4'h0, t);
  endtask

  task automatic act(input int b, input int r);
    int t;
    issue(C_ACT, b, r, 32'h0, 4'h0, t);
    if (!mopen[b]) begin mopen[b] = 1'b1; mrow[b] = r; end
  endtask

  task automatic pre(input int b);
    int t;
    issue(C_PRE, b, 0, 32'h0, 4'h0, t);
    mopen[b] = 1'b0;
  endtask

  task automatic add_words(input int b, input int c, input int t0, input int n);
    for (int k = 0; k < n; k++) begin
      exp_d[exp_n] = shadow[idx(b, mrow[b], bcol(c, k))];
      exp_c[exp_n] = t0 + CL + k;
      exp_n = exp_n + 1;
    end
  endtask

  task automatic rd(input int b, input int c, input int n, output int t0);
    issue(C_RD, b, c, 32'h0, 4'h0, t0);
    if (mopen[b]) add_words(b, c, t0, n);
  endtask

  task automatic wr_burst(input int b, input int c, input logic [3:0][31:0] d,
                          input logic [3:0][3:0] m);
    int t;
    issue(C_WR, b, c, d[0], m[0], t);
    for (int k = 1; k < 4; k++) issue(C_NOP, 0, 0, d[k], m[k], t);
    if (mopen[b])
      for (int k = 0; k < 4; k++)
        shadow[idx(b, mrow[b], bcol(c, k))] = merge(shadow[idx(b, mrow[b], bcol(c, k))], d[k], m[k]);
  endtask

  task automatic open_stream();
    exp_n = 0;
    cap_n = 0;
  endtask

  task automatic close_stream(input string req);
    idle(CL + BL + 3);
    checks++;
    if (cap_n != exp_n) begin
      errors++;
      $display("FAIL %s word count actual=%0d expected=%0d", req, cap_n, exp_n);
    end else begin
      for (int k = 0; k < exp_n; k++) begin
        if (cap_d[k] !== exp_d[k] || cap_c[k] != exp_c[k]) begin
          errors++;
          $display("FAIL %s word %0d actual=%h@%0d expected=%h@%0d",
                   req, k, cap_d[k], cap_c[k], exp_d[k], exp_c[k]);
          break;
        end
      end
    end
  endtask

  task automatic read_check(input int b, input int c, input string req);
    int t;
    open_stream();
    rd(b, c, BL, t);
    close_stream(req);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int t, t1;
    logic [3:0][31:0] d;
    logic [3:0][3:0]  m;
    void'($urandom(32'h5EED_0042));
    for (int b = 0; b < 4; b++) begin mopen[b] = 1'b0; mrow[b] = 0; end

    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (rd_valid !== 1'b0 || rd_data !== 32'h0) begin
      errors++;
      $display("FAIL R1 reset outputs actual=%b/%h expected=0/0", rd_valid, rd_data);
    end
    // R1: banks closed after reset, read yields nothing
    read_check(0, 0, "R1 closed after reset");

    // fill every word
    for (int b = 0; b < 4; b++)
      for (int r = 0; r < ROWS; r++) begin
        act(b, r);
        for (int c = 0; c < COLS; c += 4) begin
          for (int k = 0; k < 4; k++) begin d[k] = $urandom; m[k] = 4'h0; end
          wr_burst(b, c, d, m);
        end
        pre(b);
      end

    // R5 R6: latency and wrapped column order
    act(1, 5);
    read_check(1, 6, "R6 wrap from col 6");
    read_check(1, 0, "R5 aligned burst");
    read_check(1, 13, "R6 wrap from col 13");

    // R7: byte masks
    d = {32'hDDDD_DDDD, 32'hCCCC_CCCC, 32'hBBBB_BBBB, 32'hAAAA_AAAA};
    m = {4'b1111, 4'b1000, 4'b0101, 4'b0000};
    wr_burst(1, 9, d, m);
    read_check(1, 9, "R7 masked write");

    // R3: activate on an open bank keeps row 5
    act(1, 9);
    read_check(1, 0, "R3 activate ignored");

    // R2: deselected and unused codes change nothing
    open_stream();
    issue(4'b1101, 1, 0, 32'h0, 4'h0, t);
    issue(4'b1100, 1, 0, 32'h1234_5678, 4'h0, t);
    issue(4'b0001, 1, 0, 32'h0, 4'h0, t);
    issue(4'b0000, 1, 0, 32'h0, 4'h0, t);
    close_stream("R2 deselected read");
    read_check(1, 0, "R2 deselected write");

    // R8: read interrupted after two words
    open_stream();
    rd(1, 0, 2, t);
    idle(1);
    rd(1, 8, BL, t1);
    close_stream("R8 read interrupts read");

    // R8: write interrupted after two words by a write
    d = {32'h4444_0004, 32'h3333_0003, 32'h2222_0002, 32'h1111_0001};
    issue(C_WR, 1, 4, d[0], 4'h0, t);
    issue(C_NOP, 0, 0, d[1], 4'h0, t);
    issue(C_WR, 1, 12, d[2], 4'h0, t);
    for (int k = 1; k < 4; k++) issue(C_NOP, 0, 0, d[k], 4'h0, t);
    shadow[idx(1, 5, 4)] = d[0];
    shadow[idx(1, 5, 5)] = d[1];
    for (int k = 0; k < 4; k++) shadow[idx(1, 5, bcol(12, k))] = (k == 0) ? d[2] : d[k];
    read_check(1, 4, "R8 write truncated");
    read_check(1, 12, "R8 second write");

    // R9: stop after two words on read and write
    open_stream();
    rd(1, 2, 2, t);
    idle(1);
    issue(C_STOP, 0, 0, 32'h0, 4'h0, t);
    close_stream("R9 stop read");
    d = {32'h0, 32'h9999_0003, 32'h8888_0002, 32'h7777_0001};
    issue(C_WR, 1, 0, 32'h6666_0000, 4'h0, t);
    issue(C_NOP, 0, 0, d[0], 4'h0, t);
    issue(C_STOP, 0, 0, d[1], 4'h0, t);
    issue(C_NOP, 0, 0, d[2], 4'h0, t);
    shadow[idx(1, 5, 0)] = 32'h6666_0000;
    shadow[idx(1, 5, 1)] = d[0];
    read_check(1, 0, "R9 stop write");

    // R4: close one bank, read and write ignored
    act(2, 3);
    pre(1);
    read_check(1, 0, "R4 read closed bank");
    for (int k = 0; k < 4; k++) begin d[k] = 32'hDEAD_0000 + k; m[k] = 4'h0; end
    wr_burst(1, 0, d, m);
    read_check(2, 4, "R4 other bank still open");
    act(1, 5);
    read_check(1, 0, "R4 write to closed bank");

    // R10: precharge all
    act(0, 7);
    issue(C_PRE, 0, 16, 32'h0, 4'h0, t);
    for (int b = 0; b < 4; b++) mopen[b] = 1'b0;
    read_check(0, 0, "R10 bank 0 closed");
    read_check(1, 0, "R10 bank 1 closed");
    read_check(2, 0, "R10 bank 2 closed");

    // random mix
    for (int it = 0; it < 60; it++) begin
      int b, c, sel;
      b = $urandom % 4;
      c = $urandom % COLS;
      sel = $urandom % 3;
      if (!mopen[b] || sel == 0) begin
        pre(b);
        act(b, $urandom % ROWS);
      end
      if (sel == 1) begin
        for (int k = 0; k < 4; k++) begin d[k] = $urandom; m[k] = 4'($urandom); end
        wr_burst(b, c, d, m);
        read_check(b, c, "R7 random write");
      end else begin
        read_check(b, c, "R5 random read");
      end
    end

    finish_run();
  end

endmodule